// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs one memory or I/O transfer of a small 8-bit-style processor over a bus on which the low address byte and the data byte share the same lines. A caller presents a request with a 16-bit address, a direction flag, a space flag (memory or I/O) and a write byte. The sequencer then steps through a fixed pattern of bus states. In the first state it drives the address and pulses the latch enable, so that external logic can catch the low address byte. In the second state it asserts the read or write strobe. It can add wait states. In the last state it ends the strobe.

A slow target stretches the transfer by pulling `ready_in` low. The sequencer samples that input on the falling clock edge that follows the latch enable pulse, and again on every falling edge after that until it is found high. While it waits, every bus output is held exactly as it was. For a read, the byte on the shared lines is captured on the rising edge that ends the strobe and is returned with a one-clock `done` pulse.

The shared lines are modelled as a separate output, output enable and input (`ad_out`, `ad_oe`, `ad_in`), so that the pad tristate sits outside the block.

Top module: `mux_bus_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are: `ale`=0, `ad_oe`=0, `rd_n`=1, `wr_n`=1, `done`=0, and `req_ready`=1.
- R2: In the first clock after a request is accepted, `ale`=1, `ad_oe`=1, `ad_out` equals address bits [7:0] and `addr_hi` equals address bits [15:8]. `ale` is high for exactly one clock.
- R3: `io_m` is 1 for an I/O transfer and 0 for a memory transfer. It holds that value from the address clock until the next request is accepted.
- R4: On a read, from the second clock on, `ad_oe`=0 and `rd_n`=0, and `wr_n` stays 1.
- R5: On a write, from the second clock on, `ad_oe`=1, `ad_out` equals the write byte and `wr_n`=0, and `rd_n` stays 1.
- R6: If `ready_in` is high at the falling edge inside the second clock, the strobe stays low for exactly 2 clocks and `done` rises 3 clocks after the address clock.
- R7: Each consecutive falling-edge sample of `ready_in` that is low adds exactly one clock. With N low samples, the strobe stays low for N+2 clocks.
- R8: From the second clock until the strobe is released, including every wait clock, all bus outputs (`ale`, `ad_out`, `ad_oe`, `addr_hi`, `io_m`, `rd_n`, `wr_n`) keep the same values.
- R9: On a read, `rdata` equals `ad_in` as sampled at the rising edge that releases `rd_n`. It is valid in the clock where `done`=1, and `done` is high for exactly one clock.
- R10: A request is taken only while `req_ready`=1, which holds only when no transfer is in progress. A `req_valid` pulse during a transfer changes no output and starts no later transfer.
- R11: When the strobe is released, the strobe outputs return high, `ad_oe` returns to 0 and `ale` stays 0 until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; states advance on the rising edge, ready is sampled on the falling edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request |
| req_ready | output | 1 | High when idle and able to accept a request |
| req_addr | input | 16 | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_wdata | input | 8 | Write byte |
| ready_in | input | 1 | Target ready; low inserts wait clocks |
| ale | output | 1 | Address latch enable pulse |
| ad_out | output | 8 | Shared address/data lines, driven value |
| ad_oe | output | 1 | Drive enable for the shared lines |
| ad_in | input | 8 | Shared address/data lines, received value |
| addr_hi | output | 8 | High address byte |
| io_m | output | 1 | Space select, high for I/O |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Captured read byte |

## Verification
The tests run reads and writes in both address spaces with zero, one, two and three wait clocks. This tells a fixed-length sequence apart from one that counts falling-edge ready samples one by one. The bench puts the read byte on `ad_in` only during the clock before the strobe is released, so a capture made one edge early or late returns the wrong byte. Two transfers get an extra request pulse part-way through, which shows whether the sequencer ignores requests while busy or lets them disturb the address or start a second cycle.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_STRB = 3'd2,
    PH_WAIT = 3'd3,
    PH_XFER = 3'd4
  } phase_e;

  function automatic logic strobe_phase(input phase_e p);
    return (p == PH_STRB) || (p == PH_WAIT) || (p == PH_XFER);
  endfunction

endpackage

// File: rtl/mbs_ready_sampler.sv
module mbs_ready_sampler (
  input  logic clk,
  input  logic rst,
  input  logic ready_in,
  output logic ready_smp
);

  // Falling-edge sample: the state logic sees a value half a clock old at the rising edge.
  always_ff @(negedge clk) begin
    if (rst) ready_smp <= 1'b1;
    else     ready_smp <= ready_in;
  end

endmodule

// File: rtl/mbs_phase_ctrl.sv
module mbs_phase_ctrl
  import mbs_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   req_valid,
  input  logic   ready_smp,
  output phase_e cur_ph,
  output phase_e nxt_ph,
  output logic   accept,
  output logic   req_ready
);

  phase_e ph_q;

  always_comb begin
    nxt_ph = ph_q;
    unique case (ph_q)
      PH_IDLE: if (req_valid) nxt_ph = PH_ADDR;
      PH_ADDR: nxt_ph = PH_STRB;
      PH_STRB,
      PH_WAIT: nxt_ph = ready_smp ? PH_XFER : PH_WAIT;
      PH_XFER: nxt_ph = PH_IDLE;
      default: nxt_ph = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) ph_q <= PH_IDLE;
    else     ph_q <= nxt_ph;
  end

  assign cur_ph    = ph_q;
  assign req_ready = (ph_q == PH_IDLE);
  assign accept    = req_ready && req_valid;

  // R10
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_q != PH_IDLE) |=> (ph_q != PH_ADDR));

  // R7
  wait_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_WAIT && !ready_smp) |=> (ph_q == PH_WAIT));

endmodule

// File: rtl/mbs_pin_drive.sv
module mbs_pin_drive
  import mbs_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  localparam int HW = AW - DW
) (
  input  logic          clk,
  input  logic          rst,
  input  phase_e        cur_ph,
  input  phase_e        nxt_ph,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          req_io,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] ad_in,
  output logic          ale,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [HW-1:0] addr_hi,
  output logic          io_m,
  output logic          rd_n,
  output logic          wr_n,
  output logic          done,
  output logic [DW-1:0] rdata
);

  logic          wr_q;
  logic [DW-1:0] wdata_q;
  logic          nxt_strb;

  assign nxt_strb = strobe_phase(nxt_ph);

  always_ff @(posedge clk) begin
    if (rst) begin
      ale     <= 1'b0;
      ad_out  <= '0;
      ad_oe   <= 1'b0;
      addr_hi <= '0;
      io_m    <= 1'b0;
      rd_n    <= 1'b1;
      wr_n    <= 1'b1;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      ale <= (nxt_ph == PH_ADDR);
      if (accept) begin
        addr_hi <= req_addr[AW-1:DW];
        io_m    <= req_io;
        wr_q    <= req_write;
        wdata_q <= req_wdata;
        ad_out  <= req_addr[DW-1:0];
      end else if (nxt_ph == PH_STRB && wr_q) begin
        ad_out <= wdata_q;
      end
      ad_oe <= (nxt_ph == PH_ADDR) || (wr_q && nxt_strb);
      rd_n  <= !(!wr_q && nxt_strb);
      wr_n  <= !( wr_q && nxt_strb);
    end
  end

  // Read capture on the edge that releases the strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      rdata <= '0;
    end else begin
      done <= (cur_ph == PH_XFER);
      if (cur_ph == PH_XFER && !wr_q) rdata <= ad_in;
    end
  end

  // R2
  ale_single_chk: assert property (@(posedge clk) disable iff (rst) ale |=> !ale);

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst) !(!rd_n && !wr_n));

  // R5
  write_drive_chk: assert property (@(posedge clk) disable iff (rst) !wr_n |-> ad_oe);

  // R8
  wait_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_ph == PH_WAIT) |-> ($stable(ad_out) && $stable(ad_oe) && $stable(addr_hi)
                             && $stable(io_m) && $stable(rd_n) && $stable(wr_n) && !ale));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  // R11
  release_chk: assert property (@(posedge clk) disable iff (rst) $rose(wr_n) |-> !ad_oe);

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbs_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  localparam int HW = AW - DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          req_io,
  input  logic [DW-1:0] req_wdata,
  input  logic          ready_in,
  output logic          ale,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_in,
  output logic [HW-1:0] addr_hi,
  output logic          io_m,
  output logic          rd_n,
  output logic          wr_n,
  output logic          done,
  output logic [DW-1:0] rdata
);

  logic   ready_smp;
  logic   accept;
  phase_e cur_ph;
  phase_e nxt_ph;

  mbs_ready_sampler u_smp (
    .clk       (clk),
    .rst       (rst),
    .ready_in  (ready_in),
    .ready_smp (ready_smp)
  );

  mbs_phase_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .ready_smp (ready_smp),
    .cur_ph    (cur_ph),
    .nxt_ph    (nxt_ph),
    .accept    (accept),
    .req_ready (req_ready)
  );

  mbs_pin_drive #(.AW(AW), .DW(DW)) u_pins (
    .clk       (clk),
    .rst       (rst),
    .cur_ph    (cur_ph),
    .nxt_ph    (nxt_ph),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_write (req_write),
    .req_io    (req_io),
    .req_wdata (req_wdata),
    .ad_in     (ad_in),
    .ale       (ale),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .addr_hi   (addr_hi),
    .io_m      (io_m),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .done      (done),
    .rdata     (rdata)
  );

  // R3
  space_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe_phase(cur_ph)) |-> ($stable(io_m) && $stable(addr_hi)));

endmodule

// File: tb/test_mux_bus_seq.sv
module test_mux_bus_seq;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int HW = AW - DW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          req_write = 1'b0;
  logic          req_io = 1'b0;
  logic [DW-1:0] req_wdata = '0;
  logic          ready_in = 1'b1;
  logic          ale;
  logic [DW-1:0] ad_out;
  logic          ad_oe;
  logic [DW-1:0] ad_in = '0;
  logic [HW-1:0] addr_hi;
  logic          io_m;
  logic          rd_n;
  logic          wr_n;
  logic          done;
  logic [DW-1:0] rdata;

  int checks = 0;
  int fails  = 0;

  mux_bus_seq #(.AW(AW), .DW(DW)) i_mux_bus_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_io(req_io),
    .req_wdata(req_wdata), .ready_in(ready_in), .ale(ale), .ad_out(ad_out),
    .ad_oe(ad_oe), .ad_in(ad_in), .addr_hi(addr_hi), .io_m(io_m),
    .rd_n(rd_n), .wr_n(wr_n), .done(done), .rdata(rdata)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] snap();
    return {11'd0, ale, ad_oe, ad_out, addr_hi, io_m, rd_n, wr_n};
  endfunction

  task automatic reset_test();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(ale == 1'b0, "R1 ale", ale, 0);
    chk(ad_oe == 1'b0, "R1 ad_oe", ad_oe, 0);
    chk(rd_n && wr_n, "R1 strobes", {rd_n, wr_n}, 3);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
    rst = 1'b0;
  endtask

  // One transfer with n_wait low ready samples; inject = extra request mid-transfer.
  task automatic xfer_test(input logic [AW-1:0] addr, input bit io, input bit wr,
                           input logic [DW-1:0] wd, input int n_wait,
                           input logic [DW-1:0] rdin, input bit inject);
    logic [31:0] ref_s;
    int strb_cnt;
    strb_cnt = 0;
    ref_s = '0;
    @(posedge clk); #1;
    req_valid = 1'b1; req_addr = addr; req_io = io; req_write = wr; req_wdata = wd;
    ready_in = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    for (int k = 0; k <= n_wait + 4; k++) begin
      if (k > 0) begin @(posedge clk); #1; end
      ready_in = (k >= 1 && k <= n_wait) ? 1'b0 : 1'b1;
      ad_in    = (k == n_wait + 2) ? rdin : ~rdin;
      if (inject) begin
        req_valid = (k == 1);
        req_addr  = ~addr; req_io = ~io; req_write = ~wr;
      end
      if (wr ? !wr_n : !rd_n) strb_cnt++;
      if (k == 0) begin
        chk(ale == 1'b1, "R2 ale high in address clock", ale, 1);
        chk(ad_oe == 1'b1 && ad_out == addr[DW-1:0], "R2 low address on shared lines",
            {ad_oe, ad_out}, {1'b1, addr[DW-1:0]});
        chk(addr_hi == addr[AW-1:DW], "R2 high address", addr_hi, addr[AW-1:DW]);
        chk(io_m == io, "R3 space select", io_m, io);
        chk(rd_n && wr_n, "R11 no strobe in address clock", {rd_n, wr_n}, 3);
        chk(req_ready == 1'b0, "R10 busy", req_ready, 0);
      end else if (k == 1) begin
        chk(ale == 1'b0, "R2 ale one clock", ale, 0);
        if (wr)
          chk(ad_oe && ad_out == wd && !wr_n && rd_n, "R5 write drive",
              {ad_oe, ad_out, rd_n, wr_n}, {1'b1, wd, 2'b10});
        else
          chk(!ad_oe && !rd_n && wr_n, "R4 read release",
              {ad_oe, rd_n, wr_n}, 3'b001);
        ref_s = snap();
      end else if (k <= n_wait + 2) begin
        chk(snap() == ref_s, "R8 outputs frozen", snap(), ref_s);
        chk(done == 1'b0, "R7 no early done", done, 0);
      end else if (k == n_wait + 3) begin
        chk(done == 1'b1, "R6 done timing", done, 1);
        chk(rd_n && wr_n && !ad_oe && !ale, "R11 released",
            {rd_n, wr_n, ad_oe, ale}, 4'b1100);
        chk(io_m == io && addr_hi == addr[AW-1:DW], "R3 space held",
            {io_m, addr_hi}, {io, addr[AW-1:DW]});
        if (!wr) chk(rdata == rdin, "R9 read capture", rdata, rdin);
        chk(req_ready == 1'b1, "R10 idle again", req_ready, 1);
      end else begin
        chk(done == 1'b0, "R9 done one clock", done, 0);
        chk(ale == 1'b0, "R10 no extra transfer", ale, 0);
      end
    end
    chk(strb_cnt == n_wait + 2, "R7 strobe length", strb_cnt, n_wait + 2);
    if (inject) begin
      @(posedge clk); #1;
      chk(ale == 1'b0 && req_ready == 1'b1, "R10 ignored request", {ale, req_ready}, 1);
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    reset_test();
    xfer_test(16'h12A5, 1'b0, 1'b0, 8'h00, 0, 8'h3C, 1'b0);  // R6 memory read, no wait
    xfer_test(16'h00F1, 1'b1, 1'b1, 8'h96, 0, 8'h00, 1'b0);  // R5 I/O write, no wait
    xfer_test(16'hBE40, 1'b1, 1'b0, 8'h00, 3, 8'hC7, 1'b0);  // R7 I/O read, 3 waits
    xfer_test(16'h7F0E, 1'b0, 1'b1, 8'h5A, 1, 8'h00, 1'b1);  // R10 write, 1 wait, inject
    xfer_test(16'h8001, 1'b0, 1'b0, 8'h00, 2, 8'hE1, 1'b1);  // R9 read, 2 waits, inject
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule